// File: doc/BRIEF.md
# Pipelined Synchronous SRAM Access Control

This block is a single-port synchronous memory with a 32-bit word, split into four 8-bit lanes, and fully registered timing. On every rising clock edge the address, the three chip selects, the decoded write lanes and the write data are captured in an input stage. During the next clock the captured operation is performed. A write updates the selected lanes of the addressed word. A read loads the addressed word into an output register, so read data appears one clock after the capture edge. The bus itself is modelled as separate `rdata` and `drive_en` outputs. `drive_en` is the three-state control that a pad ring would use for a shared data pin.

The captured operation is tracked by a four-state machine: `ST_DESEL`, `ST_READ_FIRST`, `ST_READ` and `ST_WRITE`. The transitions, taken from any state, are:
- to `ST_DESEL` when any of the three chip selects is inactive;
- to `ST_WRITE` when the decoded lane mask is non-empty;
- to `ST_READ_FIRST` for a read captured while the current state is `ST_DESEL`;
- to `ST_READ` for any other read.

Reset enters `ST_DESEL`. A read captured in `ST_READ_FIRST` still loads the output register. Its bus drive is suppressed for that output clock. This lets several devices share one bus without contention while a newly selected bank takes over. The output enable input acts combinationally on `drive_en`.

Top module: `pipe_sram_ctrl`

## Requirements
- R1: Inputs are sampled on the rising clock edge. A selected read captured at edge k places the addressed word on `rdata` after edge k+1. `rdata` keeps that value until the next read reaches the output register.
- R2: An access is taken only when `sel_a_n`=0, `sel_b`=1 and `sel_c_n`=0 are all sampled together. Any other combination is a deselected cycle: it writes nothing and loads nothing.
- R3: `wr_all`=1 in a selected cycle writes all four lanes, whatever `wr_byte` and `lane_sel` hold.
- R4: With `wr_all`=0 and `wr_byte`=1, `lane_sel` bit i writes lane i. Lane i is `wdata[8i+7:8i]`, so bit 0 is [7:0] and bit 3 is [31:24]. Lanes that are not selected keep their contents. A selected cycle with an empty lane mask is a read.
- R5: A read captured directly after a deselected cycle (state `ST_READ_FIRST`) keeps `drive_en`=0 during its output clock. A read following a selected read or write drives the bus when `oe_n`=0.
- R6: `oe_n`=1 forces `drive_en`=0 combinationally, within the same clock.
- R7: `drive_en` is 0 in the output clock of a write cycle and in the output clock of a deselected cycle.
- R8: A read captured on the edge right after a write capture, to the same address, returns the newly written data.
- R9: While reset is asserted the state is `ST_DESEL`, `rdata` is 0 and `drive_en` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | Word address |
| sel_a_n | input | 1 | Chip select A, active low |
| sel_b | input | 1 | Chip select B, active high |
| sel_c_n | input | 1 | Chip select C, active low |
| wr_all | input | 1 | Global write, all lanes |
| wr_byte | input | 1 | Byte-write qualifier |
| lane_sel | input | LANES | Per-lane write selects |
| wdata | input | LANES*LANE_W | Write data |
| oe_n | input | 1 | Asynchronous output enable, active low |
| rdata | output | LANES*LANE_W | Registered read data |
| drive_en | output | 1 | Bus drive enable |

## Verification
If the state machine misses `ST_READ_FIRST`, a masked read is driven, or a continued read is silenced. Either error shows on `drive_en` one clock after the capture edge. A corrupted lane mask in the input stage does not show until the affected word is read back. The bench therefore re-reads every modified word and compares it with a behavioural memory. A stale or early output register shows as a wrong `rdata` value in the very cycle that follows the capture edge.

// File: rtl/sram_pkg.sv
package sram_pkg;

    typedef enum logic [1:0] {
        ST_DESEL      = 2'd0,
        ST_READ_FIRST = 2'd1,
        ST_READ       = 2'd2,
        ST_WRITE      = 2'd3
    } acc_state_e;

endpackage

// File: rtl/sram_wen_decode.sv
module sram_wen_decode #(
    parameter int LANES = 4
) (
    input  logic             wr_all,
    input  logic             wr_byte,
    input  logic [LANES-1:0] lane_sel,
    output logic [LANES-1:0] lane_we
);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_we[g] = wr_all | (wr_byte & lane_sel[g]);
    end

endmodule

// File: rtl/sram_in_stage.sv
module sram_in_stage
    import sram_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int LANES  = 4,
    parameter int LANE_W = 8,
    localparam int DATA_W = LANES * LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              chip_ok,
    input  logic [LANES-1:0]  lane_we,
    input  logic [DATA_W-1:0] wdata,
    output acc_state_e        state,
    output logic [ADDR_W-1:0] addr_q,
    output logic [LANES-1:0]  we_q,
    output logic [DATA_W-1:0] wdata_q
);

    acc_state_e state_nxt;
    logic       wants_write;

    assign wants_write = |lane_we;

    // next-state selection
    always_comb begin
        state_nxt = ST_DESEL;
        unique case (state)
            ST_DESEL: begin
                if (!chip_ok)        state_nxt = ST_DESEL;
                else if (wants_write) state_nxt = ST_WRITE;
                else                 state_nxt = ST_READ_FIRST;
            end
            ST_READ_FIRST, ST_READ, ST_WRITE: begin
                if (!chip_ok)        state_nxt = ST_DESEL;
                else if (wants_write) state_nxt = ST_WRITE;
                else                 state_nxt = ST_READ;
            end
            default: state_nxt = ST_DESEL;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_DESEL;
        else        state <= state_nxt;
    end

    // captured operands
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            we_q    <= '0;
            wdata_q <= '0;
        end else begin
            addr_q  <= addr;
            we_q    <= chip_ok ? lane_we : '0;
            wdata_q <= wdata;
        end
    end

endmodule

// File: rtl/sram_array.sv
module sram_array #(
    parameter int ADDR_W = 10,
    parameter int LANES  = 4,
    parameter int LANE_W = 8,
    localparam int DEPTH  = 1 << ADDR_W,
    localparam int DATA_W = LANES * LANE_W
) (
    input  logic              clk,
    input  logic [LANES-1:0]  we,
    input  logic [ADDR_W-1:0] word_addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rword
);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] cells [DEPTH];

        always_ff @(posedge clk) begin
            if (we[g]) cells[word_addr] <= wdata[g*LANE_W +: LANE_W];
        end

        assign rword[g*LANE_W +: LANE_W] = cells[word_addr];
    end

endmodule

// File: rtl/sram_out_stage.sv
module sram_out_stage
    import sram_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  acc_state_e        state,
    input  logic [DATA_W-1:0] rword,
    input  logic              oe_n,
    output logic [DATA_W-1:0] rdata,
    output logic              drive_en
);

    logic out_rd;
    logic out_mask;
    logic is_read;

    assign is_read = (state == ST_READ) || (state == ST_READ_FIRST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata    <= '0;
            out_rd   <= 1'b0;
            out_mask <= 1'b0;
        end else begin
            out_rd   <= is_read;
            out_mask <= (state == ST_READ_FIRST);
            if (is_read) rdata <= rword;
        end
    end

    // asynchronous output enable on top of the registered drive request
    always_comb begin
        drive_en = out_rd & ~out_mask & ~oe_n;
    end

endmodule

// File: rtl/pipe_sram_ctrl.sv
module pipe_sram_ctrl
    import sram_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int LANES  = 4,
    parameter int LANE_W = 8,
    localparam int DATA_W = LANES * LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              sel_a_n,
    input  logic              sel_b,
    input  logic              sel_c_n,
    input  logic              wr_all,
    input  logic              wr_byte,
    input  logic [LANES-1:0]  lane_sel,
    input  logic [DATA_W-1:0] wdata,
    input  logic              oe_n,
    output logic [DATA_W-1:0] rdata,
    output logic              drive_en
);

    logic              chip_ok;
    logic [LANES-1:0]  lane_we;
    acc_state_e        acc_state;
    logic [ADDR_W-1:0] addr_q;
    logic [LANES-1:0]  we_q;
    logic [DATA_W-1:0] wdata_q;
    logic [DATA_W-1:0] rword;

    assign chip_ok = ~sel_a_n & sel_b & ~sel_c_n;

    sram_wen_decode #(.LANES(LANES)) u_dec (
        .wr_all   (wr_all),
        .wr_byte  (wr_byte),
        .lane_sel (lane_sel),
        .lane_we  (lane_we)
    );

    sram_in_stage #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_in (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr    (addr),
        .chip_ok (chip_ok),
        .lane_we (lane_we),
        .wdata   (wdata),
        .state   (acc_state),
        .addr_q  (addr_q),
        .we_q    (we_q),
        .wdata_q (wdata_q)
    );

    sram_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_mem (
        .clk       (clk),
        .we        (we_q),
        .word_addr (addr_q),
        .wdata     (wdata_q),
        .rword     (rword)
    );

    sram_out_stage #(.DATA_W(DATA_W)) u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .state    (acc_state),
        .rword    (rword),
        .oe_n     (oe_n),
        .rdata    (rdata),
        .drive_en (drive_en)
    );

endmodule

// File: rtl/sram_ctrl_chk.sv
module sram_ctrl_chk #(
    parameter int LANES = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sel_a_n,
    input logic             sel_b,
    input logic             sel_c_n,
    input logic             wr_all,
    input logic             wr_byte,
    input logic [LANES-1:0] lane_sel,
    input logic             oe_n,
    input logic             drive_en,
    input logic [LANES-1:0] we_q
);

    logic sel;
    logic wreq;

    assign sel  = ~sel_a_n & sel_b & ~sel_c_n;
    assign wreq = wr_all | (wr_byte & (|lane_sel));

    AST_DESEL_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !sel |=> (we_q == '0));  // R2

    AST_GLOBAL_LANES: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && wr_all) |=> (we_q == '1));  // R3

    AST_BYTE_LANES: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && !wr_all && wr_byte) |=> (we_q == $past(lane_sel)));  // R4

    AST_FIRST_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(sel) && sel && !wreq) |-> ##2 !drive_en);  // R5

    AST_READ_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(sel) && sel && !wreq) |-> ##2 (drive_en || oe_n));  // R5

    AST_WRITE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && wreq) |-> ##2 !drive_en);  // R7

    always_comb begin
        if (rst_n === 1'b1 && oe_n === 1'b1) begin
            AST_OE_OFF: assert (!drive_en);  // R6
        end
    end

endmodule

bind pipe_sram_ctrl sram_ctrl_chk #(.LANES(LANES)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .sel_a_n  (sel_a_n),
    .sel_b    (sel_b),
    .sel_c_n  (sel_c_n),
    .wr_all   (wr_all),
    .wr_byte  (wr_byte),
    .lane_sel (lane_sel),
    .oe_n     (oe_n),
    .drive_en (drive_en),
    .we_q     (we_q)
);

// File: tb/sim_pipe_sram_ctrl.sv
module sim_pipe_sram_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 6;
    localparam int WD_CYCLES = 5000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic        sel_a_n = 1'b1;
    logic        sel_b = 1'b0;
    logic        sel_c_n = 1'b1;
    logic        wr_all = 1'b0;
    logic        wr_byte = 1'b0;
    logic [3:0]  lane_sel = '0;
    logic [31:0] wdata = '0;
    logic        oe_n = 1'b0;
    logic [31:0] rdata;
    logic        drive_en;

    int total = 0;
    int bad = 0;
    bit done = 0;
    string tag = "R9";

    always #(CLK_PERIOD/2) clk = ~clk;

    pipe_sram_ctrl #(.ADDR_W(AW)) u0 (
        .clk(clk), .rst_n(rst_n), .addr(addr),
        .sel_a_n(sel_a_n), .sel_b(sel_b), .sel_c_n(sel_c_n),
        .wr_all(wr_all), .wr_byte(wr_byte), .lane_sel(lane_sel),
        .wdata(wdata), .oe_n(oe_n), .rdata(rdata), .drive_en(drive_en)
    );

    // behavioural reference
    logic [31:0] ref_mem [int];
    bit          m_prev_sel;
    bit          m_in_rd, m_in_first;
    logic [3:0]  m_in_lanes;
    int          m_in_addr;
    logic [31:0] m_in_data;
    bit          m_out_rd, m_out_mask;
    logic [31:0] m_rdata;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_prev_sel = 0; m_in_rd = 0; m_in_first = 0; m_in_lanes = '0;
            m_out_rd = 0; m_out_mask = 0; m_rdata = '0;
        end else begin
            bit sel;
            logic [3:0] lanes;
            m_out_rd   = m_in_rd;
            m_out_mask = m_in_first;
            if (m_in_rd) m_rdata = ref_mem[m_in_addr];
            if (m_in_lanes != 0) begin
                logic [31:0] w;
                w = ref_mem.exists(m_in_addr) ? ref_mem[m_in_addr] : 32'h0;
                for (int i = 0; i < 4; i++)
                    if (m_in_lanes[i]) w[i*8 +: 8] = m_in_data[i*8 +: 8];
                ref_mem[m_in_addr] = w;
            end
            sel   = !sel_a_n && sel_b && !sel_c_n;
            lanes = wr_all ? 4'hF : (wr_byte ? lane_sel : 4'h0);
            m_in_lanes = sel ? lanes : 4'h0;
            m_in_rd    = sel && (lanes == 4'h0);
            m_in_first = m_in_rd && !m_prev_sel;
            m_prev_sel = sel;
            m_in_addr  = int'(addr);
            m_in_data  = wdata;
        end
    end

    task automatic check(string req, string what, logic [31:0] got, logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h at %0t", req, what, got, exp, $time);
        end
    endtask

    task automatic compare_all();
        check(tag, "drive_en", {31'b0, drive_en}, {31'b0, (!oe_n && m_out_rd && !m_out_mask)});
        check(tag, "rdata", rdata, m_rdata);
    endtask

    task automatic cyc(bit a_n, bit b, bit c_n, bit wa, bit wb, logic [3:0] ls,
                       int ad, logic [31:0] d);
        sel_a_n = a_n; sel_b = b; sel_c_n = c_n;
        wr_all = wa; wr_byte = wb; lane_sel = ls;
        addr = AW'(ad); wdata = d;
        @(posedge clk);
        @(negedge clk);
        compare_all();
    endtask

    task automatic rd(int ad);                 cyc(0, 1, 0, 0, 0, 4'h0, ad, 32'h0); endtask
    task automatic wr_g(int ad, logic [31:0] d, logic [3:0] ls); cyc(0, 1, 0, 1, 0, ls, ad, d); endtask
    task automatic wr_b(int ad, logic [31:0] d, logic [3:0] ls); cyc(0, 1, 0, 0, 1, ls, ad, d); endtask
    task automatic desel();                    cyc(1, 0, 1, 0, 0, 4'h0, 0, 32'h0); endtask

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        tag = "R9";
        check("R9", "drive_en in reset", {31'b0, drive_en}, 32'h0);
        check("R9", "rdata in reset", rdata, 32'h0);
        rst_n = 1'b1;

        tag = "R7_desel";
        desel();
        desel();

        tag = "R3";
        wr_g(1, 32'h1111_1111, 4'h0);
        wr_g(2, 32'h2222_2222, 4'h0);
        wr_g(3, 32'hA5A5_5A5A, 4'h3);
        wr_g(5, 32'hCAFE_F00D, 4'h5);
        wr_g(6, 32'h0BAD_BEEF, 4'h0);
        tag = "R3_R1";
        rd(5);
        rd(3);
        rd(1);

        tag = "R5";
        desel();
        rd(2);
        rd(3);
        rd(6);
        tag = "R1_hold";
        desel();
        desel();

        tag = "R4";
        rd(1);
        wr_b(1, 32'hAABB_CCDD, 4'b0001);
        wr_b(1, 32'h1234_5678, 4'b1000);
        wr_b(1, 32'h99EE_7755, 4'b0110);
        rd(1);
        rd(1);
        tag = "R4_empty";
        wr_b(2, 32'hFFFF_FFFF, 4'b0000);
        rd(2);

        tag = "R8";
        wr_g(7, 32'h7777_0007, 4'h0);
        rd(7);
        rd(7);
        wr_b(7, 32'h0000_AB00, 4'b0010);
        rd(7);
        rd(7);

        tag = "R2";
        desel();
        cyc(1, 1, 0, 1, 0, 4'h0, 2, 32'hDEAD_0001);
        cyc(0, 0, 0, 1, 0, 4'h0, 2, 32'hDEAD_0002);
        cyc(0, 1, 1, 1, 0, 4'h0, 2, 32'hDEAD_0003);
        cyc(1, 1, 0, 0, 0, 4'h0, 3, 32'h0);
        rd(2);
        rd(2);
        rd(2);

        tag = "R6";
        rd(5);
        rd(6);
        oe_n = 1'b1;
        #1;
        check("R6", "drive_en with oe_n high", {31'b0, drive_en}, 32'h0);
        oe_n = 1'b0;
        #1;
        check("R6", "drive_en with oe_n low", {31'b0, drive_en}, 32'h1);
        rd(1);
        oe_n = 1'b1;
        rd(2);
        rd(3);
        oe_n = 1'b0;
        rd(5);

        tag = "R7";
        wr_g(9, 32'h0909_0909, 4'h0);
        wr_g(10, 32'h1010_1010, 4'h0);
        rd(9);
        rd(10);
        desel();
        desel();

        tag = "R9_mid";
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check("R9", "drive_en after reset", {31'b0, drive_en}, 32'h0);
        check("R9", "rdata after reset", rdata, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        tag = "R5_after_reset";
        rd(9);
        rd(10);
        desel();

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule